// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block runs a single DMA channel from an eight-word transfer descriptor. Software, or a preceding descriptor in memory, supplies the source and destination addresses, signed per-access steps with optional address wrap windows, an access size, a per-service byte count and an iteration count. Each service request, whether a software `go` pulse or a peripheral request while requests are enabled, moves one inner block of bytes as alternating reads and writes on a simple request/acknowledge memory port. After the programmed number of services, the outer loop ends. The engine then applies end-of-loop address adjustments, raises done and an optional interrupt pulse, and reloads its iteration counter.

With chaining enabled, the end-of-loop destination adjustment word is instead the memory address of the next descriptor. The engine reads that descriptor word by word into its own registers and starts it at once if its start bit is set. Before any bus access, configuration and alignment faults are reported. Bus error responses stop the channel. Every error is held until the descriptor is rewritten.

Top module: `dmae_engine`

## Requirements
- R1: After reset there is no memory request; `active`, `done`, `irq` and `req_en` are 0 and `err_code` is 0.
- R2: Descriptor words by index: 0 source address, 1 destination address, 2 steps (bits 15:0 signed source step, 31:16 signed destination step), 3 attributes (bits 2:0 source size code, 7:3 source wrap width, 10:8 destination size code, 15:11 destination wrap width), 4 bytes per service, 5 source end adjustment, 6 destination end adjustment or next-descriptor address, 7 control (bits 14:0 iteration count, 16 start, 17 interrupt at loop end, 18 interrupt at half count, 19 drop request enable at loop end, 20 chaining). Size codes 0,1,2,4,5 mean 1,2,4,16,32 bytes; the code is driven on `mem_size`.
- R3: One service issues, until the byte count is used up, a read of the source address then a write of the destination address carrying the read data. Each address is advanced by its signed step after its access.
- R4: A nonzero wrap width w keeps all address bits above bit w-1 fixed when stepping, and the low w bits wrap.
- R5: After as many services as the 15-bit iteration count, the source gets its end adjustment, the destination gets its end adjustment (when chaining is off), and the count reloads so that further services repeat the loop from the adjusted addresses.
- R6: `active` is 1 while a service moves data and is cleared at loop end; `done` is set at loop end and is cleared when the next service begins.
- R7: `irq` is a one-cycle pulse at loop end when enabled, and after the service that leaves exactly half of the iteration count (rounded down, nonzero) when half interrupts are enabled.
- R8: A zero byte count, a zero iteration count, an unused size code, unequal source and destination size codes, or a byte count that is not a multiple of the size gives `err_code` 1 with no bus access.
- R9: A source address not aligned to the size gives `err_code` 2, and a misaligned destination gives 3, with no bus access.
- R10: An error response on a read gives `err_code` 4, and on a write gives 5. The channel stops with `active` 0. While any error is held, service requests are ignored. A descriptor write clears the error.
- R11: `hw_req` starts services only while `req_en` is 1. `req_en_set` sets it. With the drop bit set, loop end clears it.
- R12: At loop end with chaining on, the engine reads the eight words at the next-descriptor address in index order (4-byte reads, size code 2, address + 4·index) into its descriptor. If the fetched start bit is set, it begins a service without any further request.
- R13: Descriptor writes through the load port while a service or fetch is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_wr | input | 1 | Descriptor word write strobe |
| desc_idx | input | 3 | Descriptor word index |
| desc_wdata | input | 32 | Descriptor word value |
| go | input | 1 | Software service request pulse |
| hw_req | input | 1 | Peripheral service request |
| req_en_set | input | 1 | Sets the peripheral request enable |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Access byte address |
| mem_size | output | 3 | Access size code |
| mem_wdata | output | 8·DATA_BYTES | Write data, low bytes significant |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 8·DATA_BYTES | Read data, valid with `mem_ack` |
| active | output | 1 | Channel moving data |
| done | output | 1 | Outer loop completed |
| irq | output | 1 | Interrupt pulse |
| req_en | output | 1 | Peripheral request enable |
| err_code | output | 3 | Held error code |

## Verification
The hardest state to reach is a chained hand-off. It needs a completed outer loop, an eight-read descriptor fetch and an automatic restart, all without a further request. The stimulus places a second descriptor, with its start bit set, in the bench's memory model and points the first descriptor's adjustment word at it. A 600-iteration descriptor, wider than nine bits, drives the half-count interrupt and the late loop end. An injected error response at a chosen access index reaches the read and the write error paths.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
    localparam int DESC_WORDS = 8;
    localparam int ITER_W     = 15;
    localparam int W_SRC      = 0;
    localparam int W_DST      = 1;
    localparam int W_STEP     = 2;
    localparam int W_ATTR     = 3;
    localparam int W_NBYTES   = 4;
    localparam int W_SADJ     = 5;
    localparam int W_DADJ     = 6;
    localparam int W_CTL      = 7;
    localparam int CTL_START  = 16;
    localparam int CTL_IEND   = 17;
    localparam int CTL_IHALF  = 18;
    localparam int CTL_DROP   = 19;
    localparam int CTL_CHAIN  = 20;
    localparam logic [2:0] FETCH_SIZE = 3'd2;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_CFG   = 3'd1,
        ERR_SALGN = 3'd2,
        ERR_DALGN = 3'd3,
        ERR_SBUS  = 3'd4,
        ERR_DBUS  = 3'd5
    } err_t;

    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FETCH} state_t;

    typedef struct packed {
        logic [15:0] spare;
        logic [4:0]  dwrap;
        logic [2:0]  dsz;
        logic [4:0]  swrap;
        logic [2:0]  ssz;
    } attr_t;

    typedef struct packed {
        logic [15:0] dstep;
        logic [15:0] sstep;
    } steps_t;

    function automatic logic [5:0] size_bytes(logic [2:0] code);
        case (code)
            3'd0:    return 6'd1;
            3'd1:    return 6'd2;
            3'd2:    return 6'd4;
            3'd4:    return 6'd16;
            3'd5:    return 6'd32;
            default: return 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/dmae_addr_step.sv
module dmae_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [15:0]   step,
    input  logic [4:0]    wrap,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] sum;
    logic [AW-1:0] keep_low;

    always_comb begin
        sum      = cur + AW'($signed(step));
        keep_low = (wrap == 5'd0) ? '1 : ((AW'(1) << wrap) - AW'(1));
        nxt      = (cur & ~keep_low) | (sum & keep_low);
    end
endmodule

// File: rtl/dmae_check.sv
module dmae_check
    import dmae_pkg::*;
(
    input  logic [31:0]       nbytes,
    input  logic [ITER_W-1:0] iter,
    input  logic [2:0]        ssz,
    input  logic [2:0]        dsz,
    input  logic [31:0]       saddr,
    input  logic [31:0]       daddr,
    output err_t              verdict
);
    logic [31:0] lowbits;

    always_comb begin
        lowbits = 32'(size_bytes(ssz)) - 32'd1;
        if (nbytes == 32'd0 || iter == '0 || size_bytes(ssz) == 6'd0 ||
            ssz != dsz || (nbytes & lowbits) != 32'd0)
            verdict = ERR_CFG;
        else if ((saddr & lowbits) != 32'd0)
            verdict = ERR_SALGN;
        else if ((daddr & lowbits) != 32'd0)
            verdict = ERR_DALGN;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
    import dmae_pkg::*;
#(
    parameter int  DATA_BYTES = 32,
    localparam int DW         = 8 * DATA_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_wr,
    input  logic [2:0]    desc_idx,
    input  logic [31:0]   desc_wdata,
    input  logic          go,
    input  logic          hw_req,
    input  logic          req_en_set,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [2:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          active,
    output logic          done,
    output logic          irq,
    output logic          req_en,
    output logic [2:0]    err_code
);
    logic [31:0]       dw [DESC_WORDS];
    state_t            st;
    err_t              err_q;
    err_t              verdict;
    logic [ITER_W-1:0] citer;
    logic [ITER_W-1:0] biter;
    logic [ITER_W-1:0] cit_n;
    logic [31:0]       left;
    logic [31:0]       left_n;
    logic [DW-1:0]     rbuf;
    logic [2:0]        fidx;
    logic [31:0]       fbase;
    logic              auto_go;
    logic              svc;
    attr_t             attr;
    steps_t            steps;
    logic [31:0]       src_nxt;
    logic [31:0]       dst_nxt;
    logic              unused_bits;

    assign attr   = attr_t'(dw[W_ATTR]);
    assign steps  = steps_t'(dw[W_STEP]);
    assign biter  = dw[W_CTL][ITER_W-1:0];
    assign left_n = left - 32'(size_bytes(attr.ssz));
    assign cit_n  = citer - ITER_W'(1);
    assign unused_bits = ^{attr.spare, dw[W_CTL][31:CTL_CHAIN+1], dw[W_CTL][15]};

    dmae_addr_step #(.AW(32)) u_src_step (
        .cur(dw[W_SRC]), .step(steps.sstep), .wrap(attr.swrap), .nxt(src_nxt));
    dmae_addr_step #(.AW(32)) u_dst_step (
        .cur(dw[W_DST]), .step(steps.dstep), .wrap(attr.dwrap), .nxt(dst_nxt));

    dmae_check u_check (
        .nbytes(dw[W_NBYTES]), .iter(citer), .ssz(attr.ssz), .dsz(attr.dsz),
        .saddr(dw[W_SRC]), .daddr(dw[W_DST]), .verdict(verdict));

    assign svc = (st == S_IDLE) && (err_q == ERR_NONE) && !desc_wr &&
                 (go || auto_go || (hw_req && req_en));

    always_comb begin
        mem_req   = (st != S_IDLE);
        mem_we    = (st == S_WR);
        mem_wdata = rbuf;
        case (st)
            S_WR:    begin mem_addr = dw[W_DST]; mem_size = attr.dsz; end
            S_FETCH: begin mem_addr = fbase + {27'd0, fidx, 2'b00}; mem_size = FETCH_SIZE; end
            default: begin mem_addr = dw[W_SRC]; mem_size = attr.ssz; end
        endcase
    end

    assign err_code = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
            st      <= S_IDLE;
            err_q   <= ERR_NONE;
            citer   <= '0;
            left    <= '0;
            rbuf    <= '0;
            fidx    <= '0;
            fbase   <= '0;
            auto_go <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
            irq     <= 1'b0;
            req_en  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (req_en_set) req_en <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (desc_wr) begin
                        dw[desc_idx] <= desc_wdata;
                        if (desc_idx == 3'(W_CTL)) citer <= desc_wdata[ITER_W-1:0];
                        err_q <= ERR_NONE;
                    end else if (svc) begin
                        auto_go <= 1'b0;
                        done    <= 1'b0;
                        if (verdict != ERR_NONE) begin
                            err_q <= verdict;
                        end else begin
                            left   <= dw[W_NBYTES];
                            active <= 1'b1;
                            st     <= S_RD;
                        end
                    end
                end
                S_RD: if (mem_ack) begin
                    if (mem_err) begin
                        err_q  <= ERR_SBUS;
                        active <= 1'b0;
                        st     <= S_IDLE;
                    end else begin
                        rbuf      <= mem_rdata;
                        dw[W_SRC] <= src_nxt;
                        st        <= S_WR;
                    end
                end
                S_WR: if (mem_ack) begin
                    if (mem_err) begin
                        err_q  <= ERR_DBUS;
                        active <= 1'b0;
                        st     <= S_IDLE;
                    end else if (left_n != 32'd0) begin
                        dw[W_DST] <= dst_nxt;
                        left      <= left_n;
                        st        <= S_RD;
                    end else if (cit_n == '0) begin
                        dw[W_SRC] <= dw[W_SRC] + dw[W_SADJ];
                        dw[W_DST] <= dw[W_CTL][CTL_CHAIN] ? dst_nxt : dst_nxt + dw[W_DADJ];
                        citer     <= biter;
                        active    <= 1'b0;
                        done      <= 1'b1;
                        irq       <= dw[W_CTL][CTL_IEND];
                        if (dw[W_CTL][CTL_DROP]) req_en <= 1'b0;
                        if (dw[W_CTL][CTL_CHAIN]) begin
                            fbase <= dw[W_DADJ];
                            fidx  <= '0;
                            st    <= S_FETCH;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        dw[W_DST] <= dst_nxt;
                        citer     <= cit_n;
                        irq       <= dw[W_CTL][CTL_IHALF] && (cit_n == (biter >> 1));
                        active    <= 1'b0;
                        st        <= S_IDLE;
                    end
                end
                S_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        err_q <= ERR_SBUS;
                        st    <= S_IDLE;
                    end else begin
                        dw[fidx] <= mem_rdata[31:0];
                        if (fidx == 3'(W_CTL)) begin
                            citer   <= mem_rdata[ITER_W-1:0];
                            auto_go <= mem_rdata[CTL_START];
                            st      <= S_IDLE;
                        end else begin
                            fidx <= fidx + 3'd1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmae_engine_chk.sv
module dmae_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [2:0]  mem_size,
    input logic        mem_ack,
    input logic        mem_err,
    input logic        active,
    input logic        done,
    input logic        irq,
    input logic [2:0]  err_code
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_size inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5})); // R2

    AST_DONE_EXCL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && active)); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7

    AST_BUS_ERR_STOP: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_err |=> !active && !mem_req && err_code != 3'd0); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err_code != 3'd0 && !mem_req |=> !mem_req); // R8
endmodule

bind dmae_engine dmae_engine_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ack(mem_ack), .mem_err(mem_err), .active(active),
    .done(done), .irq(irq), .err_code(err_code));

// File: tb/dmae_engine_test.sv
module dmae_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 32;
    localparam int DW = 8 * DB;
    localparam logic [31:0] FBASE = 32'h0040_0000;
    localparam int LOGN = 2048;

    logic          clk = 0, rst = 1;
    logic          desc_wr = 0, go = 0, hw_req = 0, req_en_set = 0;
    logic [2:0]    desc_idx = 0;
    logic [31:0]   desc_wdata = 0;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr;
    logic [2:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 0, mem_err = 0;
    logic [DW-1:0] mem_rdata = '0;
    logic          active, done, irq, req_en;
    logic [2:0]    err_code;

    dmae_engine #(.DATA_BYTES(DB)) uut (
        .clk(clk), .rst(rst), .desc_wr(desc_wr), .desc_idx(desc_idx), .desc_wdata(desc_wdata),
        .go(go), .hw_req(hw_req), .req_en_set(req_en_set), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .active(active), .done(done), .irq(irq),
        .req_en(req_en), .err_code(err_code));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] act_a [LOGN]; logic act_w [LOGN]; logic [2:0] act_s [LOGN];
    logic [31:0] exp_a [LOGN]; logic exp_w [LOGN]; logic [2:0] exp_s [LOGN];
    int n_act = 0, n_exp = 0, data_bad = 0, irq_cnt = 0, inject_at = -1;
    logic [DW-1:0] last_rd = '0;
    logic [31:0] fmem [8];
    logic [31:0] d [8];
    logic [31:0] mw [8];
    int mcit;

    function automatic int szb(logic [2:0] c);
        case (c) 3'd0: return 1; 3'd1: return 2; 3'd2: return 4;
                 3'd4: return 16; 3'd5: return 32; default: return 0; endcase
    endfunction

    function automatic logic [31:0] stepa(logic [31:0] a, logic [15:0] off, logic [4:0] m);
        logic [31:0] s, span;
        s = a + {{16{off[15]}}, off};
        if (m == 0) return s;
        span = 32'd1 << m;
        return (a - (a % span)) + (s % span);
    endfunction

    function automatic logic [DW-1:0] pat(logic [31:0] a);
        return {(DW/32){a ^ 32'hC3A5_1E0F}};
    endfunction

    function automatic logic [31:0] ctl(int iter, bit st, bit ie, bit ih, bit dr, bit ch);
        logic [31:0] c;
        c = 32'(iter) & 32'h7FFF;
        c[16] = st; c[17] = ie; c[18] = ih; c[19] = dr; c[20] = ch;
        return c;
    endfunction

    task automatic chk(bit ok, string tag, longint a, longint e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (mem_ack) begin
            mem_ack = 0; mem_err = 0;
        end else if (mem_req) begin
            if (n_act < LOGN) begin
                act_a[n_act] = mem_addr; act_w[n_act] = mem_we; act_s[n_act] = mem_size;
            end
            mem_err = (n_act == inject_at);
            if (!mem_we) begin
                if (mem_addr >= FBASE && mem_addr < FBASE + 32)
                    mem_rdata = {{(DW-32){1'b0}}, fmem[(mem_addr - FBASE) >> 2]};
                else
                    mem_rdata = pat(mem_addr);
                last_rd = mem_rdata;
            end else begin
                logic [DW-1:0] msk;
                msk = '0;
                for (int i = 0; i < szb(mem_size) * 8; i++) msk[i] = 1'b1;
                if (((mem_wdata ^ last_rd) & msk) != '0) data_bad++;
            end
            n_act++;
            mem_ack = 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic push(logic [31:0] a, logic w, logic [2:0] s);
        if (n_exp < LOGN) begin exp_a[n_exp] = a; exp_w[n_exp] = w; exp_s[n_exp] = s; end
        n_exp++;
    endtask

    task automatic model_load();
        for (int i = 0; i < 8; i++) mw[i] = d[i];
        mcit = int'(d[7][14:0]);
    endtask

    task automatic model_svc();
        int b;
        b = szb(mw[3][2:0]);
        for (int k = 0; k < int'(mw[4]) / b; k++) begin
            push(mw[0], 0, mw[3][2:0]); mw[0] = stepa(mw[0], mw[2][15:0], mw[3][7:3]);
            push(mw[1], 1, mw[3][10:8]); mw[1] = stepa(mw[1], mw[2][31:16], mw[3][15:11]);
        end
        mcit--;
        if (mcit == 0) begin
            mw[0] = mw[0] + mw[5];
            if (!mw[7][20]) mw[1] = mw[1] + mw[6];
            mcit = int'(mw[7][14:0]);
        end
    endtask

    task automatic wr_word(int idx, logic [31:0] v);
        @(negedge clk);
        desc_wr = 1; desc_idx = 3'(idx); desc_wdata = v;
        @(negedge clk);
        desc_wr = 0;
    endtask

    task automatic load();
        for (int i = 0; i < 8; i++) wr_word(i, d[i]);
        model_load();
        n_act = 0; n_exp = 0; data_bad = 0; irq_cnt = 0; inject_at = -1;
    endtask

    task automatic settle();
        int q = 0, lim = 0;
        while (q < 3 && lim < 20000) begin
            @(negedge clk);
            if (!mem_req && !mem_ack) q++; else q = 0;
            lim++;
        end
    endtask

    task automatic kick();
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        settle();
    endtask

    task automatic cmp_log(string tag);
        int bad = -1;
        chk(n_act == n_exp, {tag, " access count"}, n_act, n_exp);
        for (int i = 0; i < n_exp && i < n_act && i < LOGN; i++)
            if (bad < 0 && (act_a[i] != exp_a[i] || act_w[i] != exp_w[i] || act_s[i] != exp_s[i]))
                bad = i;
        if (bad >= 0)
            chk(0, {tag, " access sequence"}, {act_w[bad], act_s[bad], act_a[bad]},
                {exp_w[bad], exp_s[bad], exp_a[bad]});
        else
            chk(1, tag, 0, 0);
        chk(data_bad == 0, {tag, " R3 write data"}, data_bad, 0);
    endtask

    task automatic plain(logic [31:0] s, logic [31:0] t, int code, int nb, int iter);
        d[0] = s; d[1] = t;
        d[2] = {16'(szb(3'(code))), 16'(szb(3'(code)))};
        d[3] = {16'd0, 5'd0, 3'(code), 5'd0, 3'(code)};
        d[4] = 32'(nb); d[5] = 32'd0; d[6] = 32'd0;
        d[7] = ctl(iter, 0, 1, 0, 0, 0);
    endtask

    initial begin
        logic [2:0] codes [5];
        int seed_use;
        codes = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
        seed_use = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req && !active && !done && !irq && !req_en && err_code == 0,
            "R1 reset outputs", {mem_req, active, done, irq, req_en, err_code}, 0);

        // R2 R3 R5 R6 R7: random descriptors, full loop plus one service of the next loop
        for (int t = 0; t < 8; t++) begin
            int b, iter;
            logic [2:0] c;
            c = codes[$urandom % 5];
            b = szb(c);
            iter = 1 + int'($urandom % 3);
            d[0] = 32'h0100_0000 + ($urandom % 4096) * 32;
            d[1] = 32'h0200_0000 + ($urandom % 4096) * 32;
            d[2] = {16'(b * (int'($urandom % 3) - 1)), 16'(b * (int'($urandom % 4) - 1))};
            d[3] = {16'd0, 5'd0, c, 5'd0, c};
            d[4] = 32'(b * (1 + int'($urandom % 3)));
            d[5] = 32'(32 * (int'($urandom % 8) - 4));
            d[6] = 32'(32 * (int'($urandom % 8) - 4));
            d[7] = ctl(iter, 0, 1, 0, 0, 0);
            load();
            for (int k = 0; k < iter; k++) begin kick(); model_svc(); end
            chk(done == 1 && active == 0, "R6 done at loop end", {done, active}, 2'b10);
            chk(irq_cnt == 1, "R7 end interrupt count", irq_cnt, 1);
            kick(); model_svc();
            if (iter > 1) chk(done == 0, "R6 done cleared by next service", done, 0);
            cmp_log("R5 R3 R2 random transfer");
        end

        // R4 wrap window on the source
        plain(32'h1000_00F8, 32'h2000_0000, 2, 16, 1);
        d[3][7:3] = 5'd4;
        load(); kick(); model_svc();
        cmp_log("R4 wrap");
        chk(act_a[4] == 32'h1000_00F0, "R4 wrapped address", act_a[4], 32'h1000_00F0);

        // R8 configuration faults
        plain(32'h100, 32'h200, 2, 0, 1); load(); kick();
        chk(err_code == 1 && n_act == 0, "R8 zero byte count", {err_code, 8'(n_act)}, {3'd1, 8'd0});
        plain(32'h100, 32'h200, 2, 8, 0); load(); kick();
        chk(err_code == 1 && n_act == 0, "R8 zero iteration", {err_code, 8'(n_act)}, {3'd1, 8'd0});
        plain(32'h100, 32'h200, 3, 8, 1); load(); kick();
        chk(err_code == 1 && n_act == 0, "R8 unused size code", {err_code, 8'(n_act)}, {3'd1, 8'd0});
        plain(32'h100, 32'h200, 2, 8, 1); d[3][10:8] = 3'd0; load(); kick();
        chk(err_code == 1 && n_act == 0, "R8 size mismatch", {err_code, 8'(n_act)}, {3'd1, 8'd0});
        plain(32'h100, 32'h200, 2, 6, 1); load(); kick();
        chk(err_code == 1 && n_act == 0, "R8 count not multiple", {err_code, 8'(n_act)}, {3'd1, 8'd0});

        // R9 alignment faults
        plain(32'h101, 32'h200, 1, 8, 1); load(); kick();
        chk(err_code == 2 && n_act == 0, "R9 source misaligned", {err_code, 8'(n_act)}, {3'd2, 8'd0});
        plain(32'h100, 32'h208, 4, 16, 1); load(); kick();
        chk(err_code == 3 && n_act == 0, "R9 destination misaligned", {err_code, 8'(n_act)}, {3'd3, 8'd0});

        // R10 bus errors
        plain(32'h3000, 32'h4000, 2, 8, 2); load(); inject_at = 0; kick();
        chk(err_code == 4 && !active, "R10 read error", {err_code, active}, {3'd4, 1'b0});
        kick();
        chk(n_act == 1 && err_code == 4, "R10 service ignored while error held", n_act, 1);
        load(); chk(err_code == 0, "R10 descriptor write clears error", err_code, 0);
        inject_at = 1; kick();
        chk(err_code == 5 && !active && n_act == 2, "R10 write error", {err_code, 8'(n_act)}, {3'd5, 8'd2});

        // R7 R5 half-count interrupt with a count wider than nine bits
        plain(32'h5000, 32'h6000, 0, 1, 600); d[2] = 32'd0; d[7] = ctl(600, 0, 1, 1, 0, 0);
        load();
        for (int k = 0; k < 299; k++) kick();
        chk(irq_cnt == 0, "R7 no interrupt before half", irq_cnt, 0);
        kick();
        chk(irq_cnt == 1 && !done, "R7 half interrupt", irq_cnt, 1);
        for (int k = 0; k < 299; k++) kick();
        chk(irq_cnt == 1 && !done, "R5 not finished at 599", {irq_cnt[7:0], done}, {8'd1, 1'b0});
        kick();
        chk(irq_cnt == 2 && done, "R5 finished at 600", {irq_cnt[7:0], done}, {8'd2, 1'b1});

        // R11 peripheral requests and drop of the enable
        plain(32'h7000, 32'h8000, 2, 8, 2); d[7] = ctl(2, 0, 0, 0, 1, 0); load();
        @(negedge clk); hw_req = 1;
        repeat (10) @(negedge clk);
        chk(n_act == 0, "R11 request ignored while disabled", n_act, 0);
        req_en_set = 1; @(negedge clk); req_en_set = 0;
        settle();
        hw_req = 0;
        model_svc(); model_svc();
        chk(req_en == 0 && done == 1, "R11 enable dropped at loop end", {req_en, done}, 2'b01);
        cmp_log("R11 peripheral services");

        // R12 chained descriptor fetch and automatic start
        plain(32'h9000, 32'hA000, 4, 32, 1); d[6] = FBASE; d[7] = ctl(1, 0, 1, 0, 0, 1);
        load();
        plain(32'hB000, 32'hC000, 1, 4, 1); d[7] = ctl(1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 8; i++) fmem[i] = d[i];
        kick();
        model_svc();
        for (int i = 0; i < 8; i++) push(FBASE + 32'(4 * i), 0, 3'd2);
        model_load(); model_svc();
        cmp_log("R12 chain");
        chk(irq_cnt == 2 && done, "R12 both loops ended", irq_cnt, 2);

        // R13 descriptor write during a service is ignored
        plain(32'hD000, 32'hE000, 0, 8, 2); load();
        @(negedge clk); go = 1; @(negedge clk); go = 0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1, "R13 service in progress", mem_req, 1);
        desc_wr = 1; desc_idx = 3'd0; desc_wdata = 32'hDEAD_0000;
        @(negedge clk); desc_wr = 0;
        settle();
        kick();
        model_svc(); model_svc();
        cmp_log("R13 busy write");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule